// File: doc/BRIEF.md
# Interval Tick Skip Counter

This block holds one down counter per CPU for a tick that all CPUs share. Each counter lets its CPU skip a chosen number of ticks before it is interrupted. Software loads a counter with the number of ticks to skip. Every rising edge of the tick input then lowers the counter of each CPU that is marked present. A counter that runs past zero keeps counting down from the wrapped value. It also latches a sticky overflow flag, so software can later work out how many ticks were missed after a reload.

On every tick after which a CPU's overflow flag is set, the block issues a one-cycle set pulse for that CPU. This pulse drives the CPU's timer-pending bit and its timer interrupt. The pending register is kept outside the block. The tick input may come from a foreign clock domain, so it is synchronised and edge-detected inside the block.

Top module: `tick_skip_counter`

## Requirements
- R1: After reset every counter reads zero with its overflow flag clear, and `pend_set` is low.
- R2: A write with `wr_en` high loads the addressed counter from the low 24 bits of `wr_data` and clears its overflow flag. Data bits 31:24 are ignored. The counter addresses are 0x380 for CPU 0, 0x3C0 for CPU 1, 0x700 for CPU 2 and 0x740 for CPU 3.
- R3: Each rising edge of `tick_in` lowers the 24-bit count of every present CPU by exactly one.
- R4: When a count of zero is decremented, it wraps to 0xFFFFFF and sets the overflow flag. The flag then stays set through later ticks until a write clears it.
- R5: On a tick after which a CPU's overflow flag is set, `pend_set[n]` is high for exactly one cycle. Bit n stands for pending-register bit n+4. No pulse is issued on any other cycle.
- R6: Only a rising edge of `tick_in` has an effect. Holding the input high gives a single decrement, and a falling edge changes nothing.
- R7: A CPU whose `cpu_present` bit is low keeps its counter unchanged on ticks and gets no `pend_set` pulse.
- R8: `rd_data` shows the addressed counter without delay: the overflow flag in bit 24, the count in bits 23:0, and zero above. An unmapped address reads zero, and a write to it changes no counter.
- R9: When a write and a tick update the same counter in the same cycle, the write wins. That counter takes the written value with its flag clear and gets no pulse, while the other counters still decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Shared interval tick, may be asynchronous |
| cpu_present | input | NCPU | One bit per CPU, high when the CPU is present |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte address |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Read data for `addr` |
| pend_set | output | NCPU | One-cycle set pulses for the timer-pending bits |

## Verification
The counters are loaded with different values across the CPUs: some at zero, some at one, one large. A single tick sequence therefore separates a plain decrement, a wrap with borrow, and an overflow flag that is already set and must stay set. A long high pulse on the tick input separates edge detection from level sensing. A present mask with gaps tests per-CPU gating against a global enable. A write that lands in the exact cycle of a tick, and a write to an unmapped address, test write priority and address decode.

// File: rtl/tick_skip_counter.sv
module tick_skip_counter #(
  parameter int NCPU = 4,
  parameter int CW   = 24,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_in,
  input  logic [NCPU-1:0] cpu_present,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic [NCPU-1:0] pend_set
);
  localparam int VW = CW + 1;

  function automatic logic [AW-1:0] slot_off(input int i);
    if (i < 2) return AW'(32'h380 + 32'h40 * i);
    else       return AW'(32'h700 + 32'h40 * (i - 2));
  endfunction

  logic [2:0]      sync_q;
  logic            tick_rise;
  logic [NCPU-1:0] wr_hit;
  logic [NCPU-1:0] ovf_q;
  logic [VW-1:0]   val_w [NCPU];

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tick_in};
  end
  assign tick_rise = sync_q[1] & ~sync_q[2];

  for (genvar g = 0; g < NCPU; g++) begin : g_cpu
    logic [VW-1:0] val_r;
    logic [VW-1:0] dec;
    logic [VW-1:0] nxt;
    logic          pend_r;

    assign wr_hit[g] = wr_en && (addr == slot_off(g));
    assign dec       = val_r - VW'(1);
    assign nxt       = {dec[CW] | val_r[CW], dec[CW-1:0]};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_r  <= '0;
        pend_r <= 1'b0;
      end else begin
        pend_r <= 1'b0;
        if (wr_hit[g]) begin
          val_r <= {1'b0, wr_data[CW-1:0]};
        end else if (tick_rise && cpu_present[g]) begin
          val_r  <= nxt;
          pend_r <= nxt[CW];
        end
      end
    end

    assign val_w[g]    = val_r;
    assign ovf_q[g]    = val_r[CW];
    assign pend_set[g] = pend_r;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCPU; i++)
      if (addr == slot_off(i)) rd_data = {{(DW-VW){1'b0}}, val_w[i]};
  end
endmodule

// File: rtl/tick_skip_counter_chk.sv
module tick_skip_counter_chk #(
  parameter int NCPU = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_rise,
  input logic [NCPU-1:0] cpu_present,
  input logic [NCPU-1:0] wr_hit,
  input logic [NCPU-1:0] ovf_q,
  input logic [NCPU-1:0] pend_set
);
  p_write_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_hit) |=> ((ovf_q & $past(wr_hit)) == '0));

  p_sticky_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ovf_q & ~wr_hit)) |=> ((ovf_q & $past(ovf_q & ~wr_hit)) == $past(ovf_q & ~wr_hit)));

  p_pend_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |-> $past(tick_rise));

  p_pend_has_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set & ~ovf_q) == '0);

  p_single_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);

  p_absent_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set) |-> ((pend_set & ~$past(cpu_present)) == '0));

  p_write_no_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_hit) |=> ((pend_set & $past(wr_hit)) == '0));
endmodule

bind tick_skip_counter tick_skip_counter_chk #(.NCPU(NCPU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_rise   (tick_rise),
  .cpu_present (cpu_present),
  .wr_hit      (wr_hit),
  .ovf_q       (ovf_q),
  .pend_set    (pend_set)
);

// File: tb/test_tick_skip_counter.sv
module test_tick_skip_counter;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic [3:0]  cpu_present = 4'hF;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pend_set;

  int n_run = 0;
  int n_fail = 0;
  int pend_cnt [4] = '{0, 0, 0, 0};
  logic [11:0] offs [4] = '{12'h380, 12'h3C0, 12'h700, 12'h740};

  tick_skip_counter i_tick_skip_counter (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cpu_present(cpu_present),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .pend_set(pend_set)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(negedge clk)
    for (int i = 0; i < 4; i++) if (pend_set[i]) pend_cnt[i] = pend_cnt[i] + 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_in = 1'b1;
    repeat (4) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_cnt(input string req, input int cpu, input logic [31:0] exp);
    logic [31:0] d;
    rd(offs[cpu], d);
    check(req, d, exp);
  endtask

  task automatic clear_pend();
    @(negedge clk);
    for (int i = 0; i < 4; i++) pend_cnt[i] = 0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 4; i++) expect_cnt("R1 reset count", i, 32'h0);
    check("R1 pend low", {28'h0, pend_set}, 32'h0);
  endtask

  task automatic t_write_read();
    wr(12'h380, 32'hFF12_3456);
    expect_cnt("R2/R8 upper bits dropped", 0, 32'h0012_3456);
    wr(12'h3C0, 32'h0100_0007);
    expect_cnt("R2 flag bit not written", 1, 32'h0000_0007);
    wr(12'h700, 32'h00AB_CDEF);
    expect_cnt("R2 cpu2 offset", 2, 32'h00AB_CDEF);
    wr(12'h740, 32'h0000_0042);
    expect_cnt("R2 cpu3 offset", 3, 32'h0000_0042);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(12'h384, 32'h0000_0999);
    wr(12'h400, 32'h0000_0999);
    rd(12'h400, d);
    check("R8 unmapped read", d, 32'h0);
    expect_cnt("R8 unmapped write no effect", 0, 32'h0012_3456);
    expect_cnt("R8 unmapped write no effect", 1, 32'h0000_0007);
  endtask

  task automatic t_wrap_sticky();
    wr(12'h380, 32'h1); wr(12'h3C0, 32'h0); wr(12'h700, 32'h2); wr(12'h740, 32'h10);
    clear_pend();
    tick();
    expect_cnt("R3 decrement", 0, 32'h0);
    expect_cnt("R4 wrap sets flag", 1, 32'h01FF_FFFF);
    expect_cnt("R3 decrement", 2, 32'h1);
    expect_cnt("R3 decrement", 3, 32'hF);
    check("R5 pulse cpu1", pend_cnt[1], 1);
    check("R5 no pulse cpu0", pend_cnt[0], 0);
    tick();
    expect_cnt("R4 wrap from zero", 0, 32'h01FF_FFFF);
    expect_cnt("R4 flag sticky", 1, 32'h01FF_FFFE);
    expect_cnt("R3 reach zero", 2, 32'h0);
    check("R5 pulse cpu0 once", pend_cnt[0], 1);
    check("R5 sticky pulses cpu1", pend_cnt[1], 2);
    check("R5 no pulse cpu2", pend_cnt[2], 0);
    wr(12'h3C0, 32'h3);
    expect_cnt("R2 write clears flag", 1, 32'h3);
    clear_pend();
    tick();
    expect_cnt("R3 after reload", 1, 32'h2);
    check("R5 no pulse after reload", pend_cnt[1], 0);
  endtask

  task automatic t_edge_only();
    wr(12'h740, 32'h20);
    @(negedge clk); tick_in = 1'b1;
    repeat (20) @(negedge clk);
    expect_cnt("R6 long high single decrement", 3, 32'h1F);
    tick_in = 1'b0;
    repeat (20) @(negedge clk);
    expect_cnt("R6 falling edge ignored", 3, 32'h1F);
  endtask

  task automatic t_absent();
    wr(12'h380, 32'h0); wr(12'h3C0, 32'h0); wr(12'h700, 32'h5); wr(12'h740, 32'h5);
    cpu_present = 4'b0101;
    clear_pend();
    tick();
    expect_cnt("R7 present decrements", 0, 32'h01FF_FFFF);
    expect_cnt("R7 absent held", 1, 32'h0);
    expect_cnt("R7 present decrements", 2, 32'h4);
    expect_cnt("R7 absent held", 3, 32'h5);
    check("R7 no pulse absent", pend_cnt[1], 0);
    check("R5 pulse present", pend_cnt[0], 1);
    cpu_present = 4'hF;
  endtask

  task automatic t_collision();
    wr(12'h380, 32'h0); wr(12'h700, 32'h9);
    clear_pend();
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h380; wr_data = 32'h77;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);
    expect_cnt("R9 write wins", 0, 32'h77);
    expect_cnt("R9 others tick", 2, 32'h8);
    check("R9 no pulse on written cpu", pend_cnt[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_read();
    t_unmapped();
    t_wrap_sticky();
    t_edge_only();
    t_absent();
    t_collision();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule